// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This controller-side block takes an SDR SDRAM device into its self-refresh state and brings it back out. A host raises a sleep request, together with a flag confirming that every bank is precharged. The block then issues the one-cycle entry command, with clock enable falling in that same cycle. It keeps clock enable low for as long as the device should stay asleep, and parks the command pins at a deselect pattern in the meantime.

When the host raises a wake request, the block leaves the residency no earlier than a configurable minimum. It raises clock enable and drives NOP on the command pins. It holds back its ready flag until two windows have run out: the exit window and the row-cycle window plus one recovery clock. After that the host may issue real commands again.

All windows are parameters counted in clock cycles. Normal command scheduling, refresh counting, device initialisation and clock gating belong to other blocks.

Top module: `sr_seq_ctrl`

## Requirements
- R1: When `sleep_req` and `banks_idle` are both high at a clock edge while `ready` is high, the next cycle drives the entry command for exactly one cycle: `mem_cs_n`=0, `mem_ras_n`=0, `mem_cas_n`=0, `mem_we_n`=1, `mem_cke`=0, with `ready` low.
- R2: A `sleep_req` sampled while `banks_idle` is low has no effect: the pins keep the NOP pattern (`mem_cs_n`=0, the other three strobes 1), `mem_cke` stays 1 and `ready` stays 1.
- R3: After the entry cycle, `mem_cke` stays 0 for as long as no wake request has been seen, for any length of time.
- R4: During the residency after the entry cycle, the command pins are parked at deselect: all four strobes are 1 (default `PARK_DESEL`=1).
- R5: With `wake_req` held high from the entry request onward, `mem_cke` is low for exactly 1+`MIN_RES` cycles: the entry cycle followed by `MIN_RES` parked cycles.
- R6: A single-cycle `wake_req` that is sampled during the entry cycle is remembered, and exit starts after the minimum residency without any further request.
- R7: Once `mem_cke` rises, the pins carry NOP with `ready` low for exactly max(`T_SRX`, `T_RC`+1) cycles. `ready` then goes high with NOP and `mem_cke` high.
- R8: Out of reset, and whenever `ready` is high, `mem_cke` is 1 and the pins carry NOP.
- R9: `sleep_req` is ignored during the residency and the exit window, and `wake_req` is ignored while `ready` is high.
- R10: A new self-refresh cycle can be started from the ready state after an exit, with the same entry behaviour as from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Host asks to enter self-refresh |
| banks_idle | input | 1 | Host confirms every bank is precharged |
| wake_req | input | 1 | Host asks to leave self-refresh |
| ready | output | 1 | Device may accept new commands |
| mem_cke | output | 1 | Device clock enable |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_ras_n | output | 1 | Device row strobe, active low |
| mem_cas_n | output | 1 | Device column strobe, active low |
| mem_we_n | output | 1 | Device write enable, active low |

## Verification
The hardest case to reach is a wake request that lands in the single entry cycle. It has to be remembered across the move into residency, and must not shorten the minimum residency. The stimulus re-enters from the ready state and pulses `wake_req` for exactly the one cycle in which the entry command is on the pins. It then releases the request and expects a parked residency of exactly `MIN_RES` cycles, followed by the full exit window. A second entry holds the wake request high from the start, which pins down the lower bound on residency from the other side.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ENTER = 3'd1,
      ST_SREF  = 3'd2,
      ST_EXIT  = 3'd3,
      ST_READY = 3'd4
   } sr_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sr_cmd_t;

   localparam sr_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sr_cmd_t CMD_SRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sr_seq_dcnt.sv
module sr_seq_dcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sr_seq_cmd.sv
module sr_seq_cmd
   import sr_seq_pkg::*;
#(
   parameter bit PARK_DESEL = 1'b1
) (
   input  sr_state_t st,
   output sr_cmd_t   cmd,
   output logic      cke
);
   sr_cmd_t park_cmd;

   generate
      if (PARK_DESEL) begin : g_park_desel
         assign park_cmd = CMD_DESEL;
      end else begin : g_park_nop
         assign park_cmd = CMD_NOP;
      end
   endgenerate

   always_comb begin
      cmd = CMD_NOP;
      cke = 1'b1;
      unique case (st)
         ST_ENTER: begin cmd = CMD_SRE;  cke = 1'b0; end
         ST_SREF:  begin cmd = park_cmd; cke = 1'b0; end
         default:  begin cmd = CMD_NOP;  cke = 1'b1; end
      endcase
   end
endmodule

// File: rtl/sr_seq_ctrl.sv
module sr_seq_ctrl
   import sr_seq_pkg::*;
#(
   parameter int T_SRX      = 2,
   parameter int T_RC       = 7,
   parameter int MIN_RES    = 4,
   parameter bit PARK_DESEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic banks_idle,
   input  logic wake_req,
   output logic ready,
   output logic mem_cke,
   output logic mem_cs_n,
   output logic mem_ras_n,
   output logic mem_cas_n,
   output logic mem_we_n
);
   localparam int CNT_MAX = max3(T_SRX, T_RC + 1, MIN_RES);
   localparam int CW      = $clog2(CNT_MAX + 1);

   generate
      if (T_SRX < 1)   begin : g_bad_srx $error("T_SRX must be at least 1");   end
      if (T_RC < 0)    begin : g_bad_rc  $error("T_RC must not be negative");  end
      if (MIN_RES < 1) begin : g_bad_res $error("MIN_RES must be at least 1"); end
   endgenerate

   sr_state_t st_q, st_d;
   logic      wake_pend;
   logic      res_done, srx_done, rc_done;
   logic      go_enter, go_exit;
   sr_cmd_t   cmd;

   assign go_enter = ((st_q == ST_IDLE) || (st_q == ST_READY)) && sleep_req && banks_idle;
   assign go_exit  = (st_q == ST_SREF) && (wake_req || wake_pend) && res_done;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_READY: if (go_enter) st_d = ST_ENTER;
         ST_ENTER:          st_d = ST_SREF;
         ST_SREF:           if (go_exit) st_d = ST_EXIT;
         ST_EXIT:           if (srx_done && rc_done) st_d = ST_READY;
         default:           st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wake_pend <= 1'b0;
      else if (go_exit)
         wake_pend <= 1'b0;
      else if (((st_q == ST_ENTER) || (st_q == ST_SREF)) && wake_req)
         wake_pend <= 1'b1;
   end

   sr_seq_dcnt #(.W(CW)) u_res_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(st_q == ST_ENTER), .load_val(CW'(MIN_RES - 1)),
      .done(res_done)
   );

   sr_seq_dcnt #(.W(CW)) u_srx_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(go_exit), .load_val(CW'(T_SRX - 1)),
      .done(srx_done)
   );

   sr_seq_dcnt #(.W(CW)) u_rc_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(go_exit), .load_val(CW'(T_RC)),
      .done(rc_done)
   );

   sr_seq_cmd #(.PARK_DESEL(PARK_DESEL)) u_cmd (
      .st(st_q), .cmd(cmd), .cke(mem_cke)
   );

   assign mem_cs_n  = cmd.cs_n;
   assign mem_ras_n = cmd.ras_n;
   assign mem_cas_n = cmd.cas_n;
   assign mem_we_n  = cmd.we_n;
   assign ready     = (st_q == ST_IDLE) || (st_q == ST_READY);

   AST_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cke) |-> (!mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n)); // R1
   AST_ENTRY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ENTER) |=> (st_q == ST_SREF && !mem_cke)); // R1
   AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && sleep_req && !banks_idle) |=> (ready && mem_cke)); // R2
   AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cke && !wake_req && !wake_pend) |=> !mem_cke); // R3
   AST_MIN_RES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cke) |-> $past(res_done)); // R5
   AST_WAKE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ENTER && wake_req) |=> wake_pend); // R6
   AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cke && !ready) |-> (!mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n)); // R7
   AST_EXIT_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(srx_done && rc_done)); // R7
   AST_READY_CKE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> mem_cke); // R8
endmodule

// File: tb/sr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sr_seq_ctrl_bench;
   localparam int T_SRX   = 2;
   localparam int T_RC    = 7;
   localparam int MIN_RES = 4;
   localparam int EXITN   = (T_SRX > T_RC + 1) ? T_SRX : T_RC + 1;

   // {ready, cke, cs_n, ras_n, cas_n, we_n}
   localparam logic [5:0] V_NOP  = 6'b11_0111;
   localparam logic [5:0] V_ENT  = 6'b00_0001;
   localparam logic [5:0] V_PARK = 6'b00_1111;
   localparam logic [5:0] V_EXIT = 6'b01_0111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, banks_idle = 1'b0, wake_req = 1'b0;
   logic ready, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;

   int n_cmp = 0;
   int n_bad = 0;
   logic [5:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   sr_seq_ctrl #(.T_SRX(T_SRX), .T_RC(T_RC), .MIN_RES(MIN_RES), .PARK_DESEL(1'b1)) u_sr_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .banks_idle(banks_idle),
      .wake_req(wake_req), .ready(ready), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
      .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n)
   );

   function automatic logic [5:0] pins();
      return {ready, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
   endfunction

   task automatic compare(input logic [5:0] act, input logic [5:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: applies inputs for one cycle and queues the pins expected after the edge
   task automatic step(input logic s, input logic b, input logic w,
                       input logic [5:0] exp, input string tag);
      @(negedge clk);
      sleep_req  = s;
      banks_idle = b;
      wake_req   = w;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // monitor: samples between edges and pops the scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) compare(pins(), exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(pins(), V_NOP, "R8 reset state");
      rst_n = 1'b1;

      // R9: wake ignored while ready
      step(0, 0, 1, V_NOP, "R9 wake in idle");
      step(0, 1, 1, V_NOP, "R9 wake in idle");
      // R2: sleep without banks idle
      step(1, 0, 0, V_NOP, "R2 sleep gated");
      step(1, 0, 0, V_NOP, "R2 sleep gated");
      // R1: entry
      step(1, 1, 0, V_ENT, "R1 entry command");
      // R3/R4/R9: long residency with sleep noise
      for (int i = 0; i < 20; i++) step(i[0], 1, 0, V_PARK, "R3 R4 R9 residency");
      // exit
      step(0, 0, 1, V_EXIT, "R7 exit start");
      for (int i = 1; i <= EXITN; i++)
         step(1, 1, 0, (i < EXITN) ? V_EXIT : V_NOP, "R7 R9 exit window");
      // R9: wake ignored in ready
      step(0, 1, 1, V_NOP, "R9 wake in ready");
      step(0, 1, 0, V_NOP, "R8 ready state");

      // R10 + R6: re-entry from ready, wake pulse in entry cycle
      step(1, 1, 0, V_ENT, "R10 re-entry");
      step(0, 1, 1, V_PARK, "R6 pending wake");
      for (int i = 1; i < MIN_RES; i++) step(0, 1, 0, V_PARK, "R6 min residency");
      for (int i = 0; i < EXITN; i++) step(0, 1, 0, V_EXIT, "R6 R7 exit");
      step(0, 1, 0, V_NOP, "R7 ready after exit");

      // R5: wake held from the request onward
      step(1, 1, 1, V_ENT, "R5 entry");
      for (int i = 0; i < MIN_RES; i++) step(0, 1, 1, V_PARK, "R5 min residency");
      for (int i = 0; i < EXITN; i++) step(0, 1, 1, V_EXIT, "R5 R7 exit");
      step(0, 1, 0, V_NOP, "R5 ready");
      step(0, 0, 0, V_NOP, "R8 ready idle");

      @(posedge clk);
      @(posedge clk);
      #3;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule